// File: doc/BRIEF.md
# Edge Timestamp Capture Unit

This block records when edges occur on one asynchronous input pin, measured against a local 16-bit counter. Typical uses are period measurement (capture consecutive rising edges) and pulse-width measurement (capture both edges). The pin first passes through a synchronizer. An edge detector then picks rising edges, falling edges or both. An event divider can keep only every 4th or every 16th qualified edge. Each surviving event copies the counter into a four-entry queue.

The counter advances on the enable pulse of one of several tick sources. An external pulse can clear it at any time (sync behaviour). In gated operation it instead stays at zero until that pulse arrives and runs from then on. Software drains the queue through a valid/ready read port. A not-empty flag and a sticky overflow flag report the queue state. An interrupt pulse fires after a programmable number of captures.

Read port rules: `rd_valid_o` is high whenever the queue holds data, and `rd_data_o` is then the oldest entry. An entry is removed on a clock edge where both `rd_valid_o` and `rd_ready_i` are high. `rd_ready_i` may be held low for any length of time. Captures that arrive meanwhile fill the queue and then overflow. The pin side has no back-pressure.

Top module: `cap_unit`

## Requirements
- R1: `mode_i` selects the capture condition: 00 disabled (no captures), 01 rising edges, 10 falling edges, 11 edges of both polarities.
- R2: `presc_i` divides qualified edges: 00 and 11 capture every edge, 01 every 4th, 10 every 16th.
- R3: The counter increments on each clock where the tick source selected by `tick_sel_i` (bit index into `tick_src_i`) is high. An index at or above the number of sources gives no ticks.
- R4: With `gate_mode_i`=0, a high `trig_i` clears the counter on that edge. If `trig_i` is high only at edge E0 and the pin change is first sampled at edge E0+k, with a tick every cycle, the stored value is k+1.
- R5: With `gate_mode_i`=1, the counter stays at 0 after enabling until `trig_i` is seen, then runs as in R4.
- R6: Captures are read oldest first through the valid/ready port. `not_empty_o` is high whenever at least one entry is unread. The queue holds 4 entries.
- R7: A capture arriving while the queue is full sets `ovf_o`. While `ovf_o` is set, every capture is discarded and stored entries are kept. `ovf_o` clears when the last entry is read or when `mode_i`=00.
- R8: `irq_o` is a one-cycle pulse after every (`irq_cnt_i`+1) captures, and its count restarts after each pulse.
- R9: Setting `mode_i`=00 clears the event divider count, the interrupt count and the counter.
- R10: The counter wraps from 0xFFFF to 0x0000 and raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | Asynchronous input being timed |
| mode_i | input | 2 | Capture condition (R1) |
| presc_i | input | 2 | Event divider select (R2) |
| irq_cnt_i | input | 2 | Captures per interrupt minus one (R8) |
| tick_src_i | input | NUM_SRC | Candidate tick enables |
| tick_sel_i | input | SEL_W | Index of the tick enable used |
| gate_mode_i | input | 1 | 0 clear-on-pulse, 1 hold-until-pulse |
| trig_i | input | 1 | Sync/trigger pulse |
| rd_valid_o | output | 1 | Queue has data |
| rd_ready_i | input | 1 | Reader accepts the head entry |
| rd_data_o | output | CNT_W | Oldest captured counter value |
| not_empty_o | output | 1 | Queue holds unread data |
| ovf_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | Interrupt pulse |

## Verification
The hardest condition to reach from the ports is a counter wrap observed through a capture. No register can preload the counter, so the bench clears it with one trigger pulse, lets it run more than 65536 ticks, and then places a pin edge at a computed cycle. The captured value and the unchanged overflow flag show the wrap. The second hard case is a capture while overflow is set but the queue is no longer full. The bench overfills the queue, reads one entry, sends another edge, and confirms that only three entries remain.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    CAP_OFF  = 2'b00,
    CAP_RISE = 2'b01,
    CAP_FALL = 2'b10,
    CAP_BOTH = 2'b11
  } cap_mode_e;

  function automatic logic [3:0] presc_limit(input logic [1:0] sel);
    case (sel)
      2'b01:   presc_limit = 4'd3;
      2'b10:   presc_limit = 4'd15;
      default: presc_limit = 4'd0;
    endcase
  endfunction
endpackage

// File: rtl/cap_edge.sv
module cap_edge
  import cap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pin_i,
  input  cap_mode_e mode_i,
  input  logic [1:0] presc_i,
  output logic      evt_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic [3:0]             ps_q;
  logic                   lvl, hit;
  logic [3:0]             limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign lvl   = sync_q[SYNC_STAGES-1];
  assign limit = presc_limit(presc_i);

  always_comb begin
    case (mode_i)
      CAP_RISE: hit = lvl & ~prev_q;
      CAP_FALL: hit = ~lvl & prev_q;
      CAP_BOTH: hit = lvl ^ prev_q;
      default:  hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 ps_q <= '0;
    else if (mode_i == CAP_OFF) ps_q <= '0;
    else if (hit)               ps_q <= (ps_q >= limit) ? 4'd0 : ps_q + 4'd1;
  end

  assign evt_o = hit & (ps_q >= limit);
endmodule

// File: rtl/cap_timer.sv
module cap_timer #(
  parameter int CNT_W   = 16,
  parameter int NUM_SRC = 6,
  parameter int SEL_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable_i,
  input  logic               gate_mode_i,
  input  logic               trig_i,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic [CNT_W-1:0]   cnt_o
);
  localparam int PAD = 1 << SEL_W;

  logic [PAD-1:0]   src_pad;
  logic             running_q, tick;
  logic [CNT_W-1:0] cnt_q;

  for (genvar i = 0; i < PAD; i++) begin : g_pad
    if (i < NUM_SRC) begin : g_src
      assign src_pad[i] = src_i[i];
    end else begin : g_zero
      assign src_pad[i] = 1'b0;
    end
  end

  assign tick = src_pad[sel_i];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      running_q <= 1'b0;
    end else if (!enable_i) begin
      cnt_q     <= '0;
      running_q <= 1'b0;
    end else if (trig_i) begin
      cnt_q     <= '0;
      running_q <= 1'b1;
    end else if (tick && (running_q || !gate_mode_i)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/cap_fifo.sv
module cap_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_ovf_i,
  input  logic         wr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         rd_ready_i,
  output logic         rd_valid_o,
  output logic [W-1:0] rd_data_o,
  output logic         ovf_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0] FULL_L = AW'(DEPTH) | (AW+1)'(0);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wptr_q, rptr_q, used;
  logic         full, push, pop, ovf_q;

  assign used       = wptr_q - rptr_q;
  assign full       = (used == (AW+1)'(DEPTH));
  assign rd_valid_o = (used != '0);
  assign pop        = rd_valid_o & rd_ready_i;
  assign push       = wr_i & ~full & ~ovf_q;
  assign rd_data_o  = mem[rptr_q[AW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (push) wptr_q <= (wptr_q[AW-1:0] == AW'(DEPTH-1)) ?
                          {~wptr_q[AW], {AW{1'b0}}} : wptr_q + 1'b1;
      if (pop)  rptr_q <= (rptr_q[AW-1:0] == AW'(DEPTH-1)) ?
                          {~rptr_q[AW], {AW{1'b0}}} : rptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wptr_q[AW-1:0]] <= wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              ovf_q <= 1'b0;
    else if (clr_ovf_i)                      ovf_q <= 1'b0;
    else if (wr_i && full)                   ovf_q <= 1'b1;
    else if (pop && used == (AW+1)'(1))      ovf_q <= 1'b0;
  end

  assign ovf_o = ovf_q;

  logic unused_full_l;
  assign unused_full_l = ^FULL_L;
endmodule

// File: rtl/cap_unit.sv
module cap_unit
  import cap_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DEPTH       = 4,
  parameter int NUM_SRC     = 6,
  parameter int SEL_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pin_i,
  input  logic [1:0]         mode_i,
  input  logic [1:0]         presc_i,
  input  logic [1:0]         irq_cnt_i,
  input  logic [NUM_SRC-1:0] tick_src_i,
  input  logic [SEL_W-1:0]   tick_sel_i,
  input  logic               gate_mode_i,
  input  logic               trig_i,
  output logic               rd_valid_o,
  input  logic               rd_ready_i,
  output logic [CNT_W-1:0]   rd_data_o,
  output logic               not_empty_o,
  output logic               ovf_o,
  output logic               irq_o
);
  cap_mode_e        mode;
  logic             cap_evt, enabled;
  logic [CNT_W-1:0] tmr_cnt;
  logic [1:0]       irq_q_cnt;
  logic             irq_q;

  assign mode    = cap_mode_e'(mode_i);
  assign enabled = (mode != CAP_OFF);

  cap_edge #(.SYNC_STAGES(SYNC_STAGES)) i_edge (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .mode_i(mode),
    .presc_i(presc_i), .evt_o(cap_evt)
  );

  cap_timer #(.CNT_W(CNT_W), .NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) i_timer (
    .clk(clk), .rst_n(rst_n), .enable_i(enabled), .gate_mode_i(gate_mode_i),
    .trig_i(trig_i), .src_i(tick_src_i), .sel_i(tick_sel_i), .cnt_o(tmr_cnt)
  );

  cap_fifo #(.W(CNT_W), .DEPTH(DEPTH)) i_fifo (
    .clk(clk), .rst_n(rst_n), .clr_ovf_i(!enabled), .wr_i(cap_evt),
    .wr_data_i(tmr_cnt), .rd_ready_i(rd_ready_i), .rd_valid_o(rd_valid_o),
    .rd_data_o(rd_data_o), .ovf_o(ovf_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q_cnt <= '0;
      irq_q     <= 1'b0;
    end else if (!enabled) begin
      irq_q_cnt <= '0;
      irq_q     <= 1'b0;
    end else if (cap_evt) begin
      if (irq_q_cnt == irq_cnt_i) begin
        irq_q_cnt <= '0;
        irq_q     <= 1'b1;
      end else begin
        irq_q_cnt <= irq_q_cnt + 2'd1;
        irq_q     <= 1'b0;
      end
    end else begin
      irq_q <= 1'b0;
    end
  end

  assign irq_o       = irq_q;
  assign not_empty_o = rd_valid_o;
endmodule

// File: rtl/cap_unit_chk.sv
module cap_unit_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode_i,
  input logic             trig_i,
  input logic             cap_evt,
  input logic [CNT_W-1:0] tmr_cnt,
  input logic             irq_o,
  input logic             ovf_o,
  input logic             not_empty_o,
  input logic             rd_valid_o,
  input logic             rd_ready_i
);
  a_r9_off_clears_counter: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b00) |=> (tmr_cnt == '0));

  a_r4_trig_clears_counter: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != 2'b00 && trig_i) |=> (tmr_cnt == '0));

  a_r6_fill_needs_capture: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(not_empty_o) |-> $past(cap_evt));

  a_r7_ovf_implies_data: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> not_empty_o);

  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && mode_i != 2'b00 && !(rd_valid_o && rd_ready_i)) |=> ovf_o);

  a_r8_irq_after_capture: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(cap_evt));
endmodule

bind cap_unit cap_unit_chk #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .trig_i(trig_i),
  .cap_evt(cap_evt), .tmr_cnt(tmr_cnt), .irq_o(irq_o), .ovf_o(ovf_o),
  .not_empty_o(not_empty_o), .rd_valid_o(rd_valid_o), .rd_ready_i(rd_ready_i)
);

// File: tb/test_cap_unit.sv
module test_cap_unit;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        pin = 1'b0, trig = 1'b0, gate = 1'b0, rdy = 1'b0;
  logic [1:0]  mode = 2'b00, presc = 2'b00, irqc = 2'b00;
  logic [5:0]  src = 6'b000001;
  logic [2:0]  sel = 3'd0;
  logic        rd_valid, not_empty, ovf, irq;
  logic [15:0] rd_data;
  int          n_chk = 0, n_bad = 0, irq_seen = 0, cyc = 0;
  logic [15:0] got [8];
  int          n_got;

  always #10 clk = ~clk;

  cap_unit i_cap_unit (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .mode_i(mode), .presc_i(presc),
    .irq_cnt_i(irqc), .tick_src_i(src), .tick_sel_i(sel), .gate_mode_i(gate),
    .trig_i(trig), .rd_valid_o(rd_valid), .rd_ready_i(rdy), .rd_data_o(rd_data),
    .not_empty_o(not_empty), .ovf_o(ovf), .irq_o(irq)
  );

  always @(negedge clk) begin
    cyc++;
    if (irq) irq_seen++;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      pin = 1'b1; repeat (3) @(negedge clk);
      pin = 1'b0; repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic drain();
    n_got = 0;
    while (rd_valid) begin
      if (n_got < 8) got[n_got] = rd_data;
      n_got++;
      rdy = 1'b1; @(negedge clk); rdy = 1'b0;
    end
  endtask

  task automatic pop_one();
    rdy = 1'b1; @(negedge clk); rdy = 1'b0;
  endtask

  task automatic disable_unit();
    mode = 2'b00; repeat (2) @(negedge clk);
    drain();
  endtask

  // trigger pulse at edge E0, then leave the pin change sampled at E0+k
  task automatic trig_wait(input int k);
    trig = 1'b1; @(negedge clk); trig = 1'b0;
    repeat (k - 1) @(negedge clk);
  endtask

  // {mode, presc, pulses, raw captures}
  localparam logic [15:0] VEC [11] = '{
    {2'b01, 2'b00, 6'd3,  6'd3},
    {2'b10, 2'b00, 6'd3,  6'd3},
    {2'b11, 2'b00, 6'd2,  6'd4},
    {2'b01, 2'b00, 6'd6,  6'd6},
    {2'b01, 2'b01, 6'd8,  6'd2},
    {2'b11, 2'b01, 6'd6,  6'd3},
    {2'b01, 2'b10, 6'd16, 6'd1},
    {2'b11, 2'b10, 6'd16, 6'd2},
    {2'b00, 2'b00, 6'd3,  6'd0},
    {2'b01, 2'b11, 6'd2,  6'd2},
    {2'b11, 2'b10, 6'd17, 6'd2}
  };

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    // reset state
    chk("R6 reset not_empty", int'(not_empty), 0);
    chk("R7 reset ovf", int'(ovf), 0);
    chk("R8 reset irq", int'(irq), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // vector table: R1 mode, R2 divider, R6/R7 fill and overflow
    foreach (VEC[v]) begin
      int raw, expn;
      disable_unit();
      mode = VEC[v][15:14]; presc = VEC[v][13:12];
      @(negedge clk);
      pulses(int'(VEC[v][11:6]));
      raw  = int'(VEC[v][5:0]);
      expn = (raw > 4) ? 4 : raw;
      chk($sformatf("R1/R2 vec%0d not_empty", v), int'(not_empty), int'(raw > 0));
      chk($sformatf("R7 vec%0d ovf", v), int'(ovf), int'(raw > 4));
      drain();
      chk($sformatf("R6 vec%0d entries", v), n_got, expn);
      chk($sformatf("R7 vec%0d ovf after full read", v), int'(ovf), 0);
    end

    // R4 capture value and R6 read order
    disable_unit();
    presc = 2'b00; mode = 2'b01; gate = 1'b0; @(negedge clk);
    trig_wait(10);
    pulses(2);
    drain();
    chk("R6 two entries", n_got, 2);
    chk("R4 first stamp", int'(got[0]), 11);
    chk("R6 order second stamp", int'(got[1]), 17);

    // R3 unselected or out-of-range tick source freezes counter
    disable_unit();
    mode = 2'b01; sel = 3'd2; @(negedge clk);
    trig_wait(10);
    pulses(1);
    drain();
    chk("R3 idle source stamp", int'(got[0]), 0);
    disable_unit();
    mode = 2'b01; sel = 3'd7; @(negedge clk);
    trig_wait(10);
    pulses(1);
    drain();
    chk("R3 out-of-range source stamp", int'(got[0]), 0);
    sel = 3'd0;

    // R5 gated operation holds counter until trigger
    disable_unit();
    gate = 1'b1; mode = 2'b01; repeat (20) @(negedge clk);
    pulses(1);
    trig_wait(10);
    pulses(1);
    drain();
    chk("R5 stamp before trigger", int'(got[0]), 0);
    chk("R5 stamp after trigger", int'(got[1]), 11);
    gate = 1'b0;

    // R10 wrap, no flag
    disable_unit();
    mode = 2'b01; @(negedge clk);
    trig_wait(65540);
    pulses(1);
    chk("R10 no ovf on wrap", int'(ovf), 0);
    drain();
    chk("R10 wrapped stamp", int'(got[0]), 5);

    // R7 captures discarded while ovf set, even after a read
    disable_unit();
    mode = 2'b01; @(negedge clk);
    pulses(5);
    chk("R7 ovf set", int'(ovf), 1);
    pop_one();
    pulses(1);
    chk("R7 ovf still set", int'(ovf), 1);
    drain();
    chk("R7 discarded while ovf", n_got, 3);
    chk("R7 ovf cleared by read", int'(ovf), 0);
    pulses(5);
    mode = 2'b00; @(negedge clk);
    chk("R7 ovf cleared by disable", int'(ovf), 0);

    // R8 interrupt cadence
    disable_unit();
    irqc = 2'b01; irq_seen = 0; mode = 2'b01; @(negedge clk);
    pulses(4);
    chk("R8 irq every 2nd", irq_seen, 2);
    disable_unit();
    irqc = 2'b11; irq_seen = 0; mode = 2'b01; @(negedge clk);
    pulses(4);
    chk("R8 irq every 4th", irq_seen, 1);
    disable_unit();
    irqc = 2'b00; irq_seen = 0; mode = 2'b01; @(negedge clk);
    pulses(3);
    chk("R8 irq every capture", irq_seen, 3);

    // R9 disable clears interrupt count and divider count
    disable_unit();
    irqc = 2'b11; irq_seen = 0; mode = 2'b01; @(negedge clk);
    pulses(3);
    disable_unit();
    mode = 2'b01; @(negedge clk);
    pulses(3);
    chk("R9 irq count restarted", irq_seen, 0);
    pulses(1);
    chk("R9 irq after four fresh", irq_seen, 1);
    disable_unit();
    irqc = 2'b00; presc = 2'b01; mode = 2'b01; @(negedge clk);
    pulses(3);
    chk("R9 divider holds three", int'(not_empty), 0);
    disable_unit();
    mode = 2'b01; @(negedge clk);
    pulses(1);
    chk("R9 divider restarted", int'(not_empty), 0);
    pulses(3);
    chk("R9 divider fires at four", int'(not_empty), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule